// File: doc/BRIEF.md
# Rotating Bit-Array Triplet Finder

This block searches one event's hits on three concentric cylindrical layers for three-layer track candidates. Hits from the two inner layers are stored as single bits in two azimuth-indexed arrays. Before it is stored, each inner coordinate is multiplied by a fixed per-layer radius factor. Once the inner layers are loaded, outer-layer hits are streamed in, one per clock.

For each outer hit, both arrays are rotated by the outer azimuth. A single shared coincidence network then tests the rotated arrays against a fixed table of circular-track hypotheses. Each hypothesis is a pair of relative azimuth offsets. Because the offsets are relative to the outer hit, one set of coincidence gates serves every outer azimuth.

Matching hypotheses leave the block one per transfer on a valid/ready port, lowest index first. The first result is available on the cycle after the outer hit is accepted. An end-of-event strobe empties both arrays in a single cycle, so loading of the next event can begin at once.

Top module: `triplet_finder`

## Requirements
- R1: After reset, `trip_valid` is 0, `hit_ready` is 1, `drop_count` is 0 and both inner arrays are empty.
- R2: A hit is taken on a clock edge where `hit_valid` and `hit_ready` are both 1. The value of `hit_layer` selects the action: 1 writes inner array one, 2 writes inner array two, 3 is an outer-hit query.
- R3: An inner hit with azimuth `phi` sets bin floor(phi*K/256) mod 128. K is 256 for layer 1 and 192 for layer 2 by default.
- R4: Pattern p is stored as a pair of codes (d+64) for signed offsets (d1,d2). It matches outer azimuth f when bin (f+d1) mod 128 of array one and bin (f+d2) mod 128 of array two are both set. Wraparound is modulo 128. The default (d1,d2) pairs are p0=(0,0), p1=(+2,+1), p2=(-2,-1) and p3=(+5,+3).
- R5: All patterns matched by one outer hit are emitted one per transfer in ascending pattern index. Each transfer carries the index on `trip_pat` and the outer azimuth on `trip_phi`.
- R6: While matches of an outer hit remain to be emitted, `hit_ready` is 0. An outer hit with no match produces no output, and `hit_ready` stays 1.
- R7: A cycle with `evt_end` high empties both arrays. An inner hit accepted in that same cycle is kept and belongs to the next event.
- R8: A hit with `hit_layer` 0 changes no array and produces no output. It increments `drop_count`, an 8-bit counter that saturates at 255.
- R9: While `trip_valid` is 1 and `trip_ready` is 0, `trip_valid`, `trip_pat` and `trip_phi` hold their values.
- R10: The first match of an outer hit appears on `trip_valid` on the cycle after that hit is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | Hit present |
| hit_ready | output | 1 | Block can take a hit |
| hit_layer | input | 2 | Layer tag: 0 ignored, 1 and 2 inner, 3 outer |
| hit_phi | input | 7 | Azimuth bin |
| evt_end | input | 1 | End-of-event strobe, empties the arrays |
| trip_valid | output | 1 | Triplet result present |
| trip_ready | input | 1 | Consumer takes the result |
| trip_pat | output | 2 | Index of the matched pattern |
| trip_phi | output | 7 | Azimuth of the outer hit |
| drop_count | output | 8 | Saturating count of hits with tag 0 |

## Verification
An inner hit driven in one cycle is visible to an outer query issued in the following cycle. The first match of an outer hit is due one clock after acceptance, and each later match is due one clock after the previous transfer. The bench drives each hit for exactly one edge and samples on the falling edge right after it. It then walks the expected match list, computed from its own copy of the arrays and the pattern table, one falling edge per transfer. When `trip_ready` is held low, the first result is re-sampled on several falling edges before any transfer is allowed.

// File: rtl/tf_pkg.sv
package tf_pkg;
    localparam int PHI_W_DEF = 7;
    localparam int NPAT_DEF  = 4;

    typedef enum logic [1:0] {
        LYR_NONE = 2'd0,
        LYR_IN1  = 2'd1,
        LYR_IN2  = 2'd2,
        LYR_OUT  = 2'd3
    } layer_e;

    typedef struct packed {
        layer_e                 layer;
        logic [PHI_W_DEF-1:0]   phi;
    } hit_t;
endpackage

// File: rtl/tf_bitarray.sv
module tf_bitarray #(
    parameter int PHI_W = 7,
    parameter int SCALE = 256
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  wr_en,
    input  logic [PHI_W-1:0]      wr_phi,
    output logic [(1<<PHI_W)-1:0] bits
);
    localparam int NB = 1 << PHI_W;
    localparam int PW = PHI_W + 9;
    localparam logic [PW-1:0] SCALE_V = PW'(SCALE);

    logic [PW-1:0]    prod;
    logic [PHI_W-1:0] idx;

    assign prod = {9'd0, wr_phi} * SCALE_V;
    assign idx  = prod[PHI_W+7:8];

    always_ff @(posedge clk) begin
        if (rst) begin
            bits <= '0;
        end else begin
            if (clr)   bits <= '0;
            if (wr_en) bits[idx] <= 1'b1;
        end
    end

    assert_clear_empties_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && !wr_en) |=> (bits == '0));

    assert_write_sets_bin_R3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> bits[$past(idx)]);
endmodule

// File: rtl/tf_rotator.sv
module tf_rotator #(
    parameter int PHI_W = 7
) (
    input  logic [(1<<PHI_W)-1:0] din,
    input  logic [PHI_W-1:0]      sh,
    output logic [(1<<PHI_W)-1:0] dout
);
    localparam int NB = 1 << PHI_W;

    logic [PHI_W:0][NB-1:0] stg;

    assign stg[0] = din;

    for (genvar s = 0; s < PHI_W; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stg[s+1] = sh[s] ? {stg[s][D-1:0], stg[s][NB-1:D]} : stg[s];
    end

    assign dout = stg[PHI_W];

    always_comb begin
        assert_rot_base_R4: assert (dout[0] == din[sh]);
    end
endmodule

// File: rtl/tf_prienc.sv
module tf_prienc #(
    parameter int N = 4
) (
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);

    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant = '0;
                grant[i] = 1'b1;
                idx   = IW'(i);
            end
        end
    end

    always_comb begin
        assert_grant_lowest_R5: assert ($onehot0(grant) && ((grant & req) == grant)
            && (((grant - 1'b1) & req) == '0 || grant == '0));
    end
endmodule

// File: rtl/triplet_finder.sv
module triplet_finder #(
    parameter int                          PHI_W  = tf_pkg::PHI_W_DEF,
    parameter int                          NPAT   = tf_pkg::NPAT_DEF,
    parameter logic [NPAT*PHI_W-1:0]       PAT_D1 = {7'd69, 7'd62, 7'd66, 7'd64},
    parameter logic [NPAT*PHI_W-1:0]       PAT_D2 = {7'd67, 7'd63, 7'd65, 7'd64},
    parameter int                          SCALE1 = 256,
    parameter int                          SCALE2 = 192,
    parameter int                          CNT_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    hit_valid,
    output logic                    hit_ready,
    input  logic [1:0]              hit_layer,
    input  logic [PHI_W-1:0]        hit_phi,
    input  logic                    evt_end,
    output logic                    trip_valid,
    input  logic                    trip_ready,
    output logic [$clog2(NPAT)-1:0] trip_pat,
    output logic [PHI_W-1:0]        trip_phi,
    output logic [CNT_W-1:0]        drop_count
);
    import tf_pkg::*;

    localparam int NB = 1 << PHI_W;
    localparam logic [PHI_W-1:0] BIAS = {1'b1, {(PHI_W-1){1'b0}}};

    layer_e           lyr;
    logic             accept, wr1, wr2, q_out, drop;
    logic [NB-1:0]    arr1, arr2, rot1, rot2;
    logic [NPAT-1:0]  match, pend, grant;
    logic [PHI_W-1:0] phi3;

    assign lyr    = layer_e'(hit_layer);
    assign accept = hit_valid && hit_ready;
    assign wr1    = accept && (lyr == LYR_IN1);
    assign wr2    = accept && (lyr == LYR_IN2);
    assign q_out  = accept && (lyr == LYR_OUT);
    assign drop   = accept && (lyr == LYR_NONE);

    tf_bitarray #(.PHI_W(PHI_W), .SCALE(SCALE1)) u_arr1 (
        .clk(clk), .rst(rst), .clr(evt_end), .wr_en(wr1), .wr_phi(hit_phi), .bits(arr1));
    tf_bitarray #(.PHI_W(PHI_W), .SCALE(SCALE2)) u_arr2 (
        .clk(clk), .rst(rst), .clr(evt_end), .wr_en(wr2), .wr_phi(hit_phi), .bits(arr2));

    tf_rotator #(.PHI_W(PHI_W)) u_rot1 (.din(arr1), .sh(hit_phi), .dout(rot1));
    tf_rotator #(.PHI_W(PHI_W)) u_rot2 (.din(arr2), .sh(hit_phi), .dout(rot2));

    // Shared coincidence network: code (d+BIAS) maps to rotated bin d mod NB.
    for (genvar p = 0; p < NPAT; p++) begin : g_pat
        localparam logic [PHI_W-1:0] I1 = PAT_D1[p*PHI_W +: PHI_W] ^ BIAS;
        localparam logic [PHI_W-1:0] I2 = PAT_D2[p*PHI_W +: PHI_W] ^ BIAS;
        assign match[p] = rot1[I1] & rot2[I2];
    end

    tf_prienc #(.N(NPAT)) u_enc (.req(pend), .grant(grant), .idx(trip_pat));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            phi3 <= '0;
        end else if (q_out) begin
            pend <= match;
            phi3 <= hit_phi;
        end else if (trip_valid && trip_ready) begin
            pend <= pend & ~grant;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                          drop_count <= '0;
        else if (drop && drop_count != '1) drop_count <= drop_count + 1'b1;
    end

    assign hit_ready  = (pend == '0);
    assign trip_valid = (pend != '0);
    assign trip_phi   = phi3;

    assert_hold_under_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (trip_valid && !trip_ready) |=>
        (trip_valid && $stable(trip_pat) && $stable(trip_phi)));

    assert_result_follows_query_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(trip_valid) |-> $past(q_out));

    assert_drop_counts_R8: assert property (@(posedge clk) disable iff (rst)
        (drop && drop_count != '1) |=> (drop_count == $past(drop_count) + 1'b1));

    assert_no_take_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (trip_valid && !trip_ready) |=> $stable(arr1) && $stable(arr2) || $past(evt_end));
endmodule

// File: tb/triplet_finder_tb.sv
`timescale 1ns/1ps
module triplet_finder_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       hit_valid, hit_ready, evt_end, trip_valid, trip_ready;
    logic [1:0] hit_layer, trip_pat;
    logic [6:0] hit_phi, trip_phi;
    logic [7:0] drop_count;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [127:0] m1, m2;
    int drops = 0;
    int d1 [4] = '{0, 2, -2, 5};
    int d2 [4] = '{0, 1, -1, 3};

    always #2 clk = ~clk;

    triplet_finder u_dut (
        .clk(clk), .rst(rst), .hit_valid(hit_valid), .hit_ready(hit_ready),
        .hit_layer(hit_layer), .hit_phi(hit_phi), .evt_end(evt_end),
        .trip_valid(trip_valid), .trip_ready(trip_ready), .trip_pat(trip_pat),
        .trip_phi(trip_phi), .drop_count(drop_count));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int bin_of(input int lyr, input int phi);
        return (lyr == 1) ? phi : ((phi * 192) / 256) % 128;
    endfunction

    task automatic model_put(input int lyr, input int phi);
        if (lyr == 1) m1[bin_of(1, phi)] = 1'b1;
        if (lyr == 2) m2[bin_of(2, phi)] = 1'b1;
        if (lyr == 0 && drops < 255) drops++;
    endtask

    task automatic put(input int lyr, input int phi);
        @(negedge clk);
        chk(hit_ready == 1'b1, "R6 ready before hit", int'(hit_ready), 1);
        hit_valid = 1'b1; hit_layer = 2'(lyr); hit_phi = 7'(phi);
        @(negedge clk);
        hit_valid = 1'b0;
        model_put(lyr, phi);
    endtask

    task automatic end_event(input bit with_hit, input int phi);
        @(negedge clk);
        evt_end = 1'b1;
        if (with_hit) begin hit_valid = 1'b1; hit_layer = 2'd1; hit_phi = 7'(phi); end
        @(negedge clk);
        evt_end = 1'b0; hit_valid = 1'b0;
        m1 = '0; m2 = '0;
        if (with_hit) model_put(1, phi);
    endtask

    // Send an outer hit and check every expected result; hold = cycles of stall on the first.
    task automatic outer(input int phi, input int hold, input string req);
        int exp_list [4];
        int n = 0;
        for (int p = 0; p < 4; p++)
            if (m1[(phi + d1[p] + 128) % 128] && m2[(phi + d2[p] + 128) % 128]) begin
                exp_list[n] = p; n++;
            end
        @(negedge clk);
        hit_valid = 1'b1; hit_layer = 2'd3; hit_phi = 7'(phi);
        if (hold > 0) trip_ready = 1'b0;
        @(negedge clk);
        hit_valid = 1'b0;
        if (n > 0) begin
            chk(trip_valid == 1'b1, {req, " R10 first result due"}, int'(trip_valid), 1);
            for (int h = 0; h < hold; h++) begin
                chk(trip_valid && trip_pat == 2'(exp_list[0]) && trip_phi == 7'(phi),
                    {req, " R9 held"}, int'(trip_pat), exp_list[0]);
                @(negedge clk);
            end
            trip_ready = 1'b1;
        end
        for (int k = 0; k < n; k++) begin
            chk(trip_valid == 1'b1, {req, " R5 valid"}, int'(trip_valid), 1);
            chk(trip_pat == 2'(exp_list[k]), {req, " R5 pattern order"}, int'(trip_pat), exp_list[k]);
            chk(trip_phi == 7'(phi), {req, " R5 outer azimuth"}, int'(trip_phi), phi);
            chk(hit_ready == 1'b0, {req, " R6 stalled"}, int'(hit_ready), 0);
            @(negedge clk);
        end
        chk(trip_valid == 1'b0, {req, " R6 drained"}, int'(trip_valid), 0);
        chk(hit_ready == 1'b1, {req, " R6 ready again"}, int'(hit_ready), 1);
    endtask

    task automatic t_reset;
        chk(trip_valid == 1'b0, "R1 valid low", int'(trip_valid), 0);
        chk(hit_ready == 1'b1, "R1 ready high", int'(hit_ready), 1);
        chk(drop_count == 8'd0, "R1 drop count", int'(drop_count), 0);
        outer(10, 0, "R1 empty arrays");
    endtask

    task automatic t_single;
        end_event(0, 0);
        put(1, 10); put(2, 14);
        chk(m1[10] && m2[10], "R2 model setup", 1, 1);
        outer(10, 0, "R2 R4 single match");
        outer(11, 0, "R4 no match");
    endtask

    task automatic t_multi;
        end_event(0, 0);
        put(1, 50); put(1, 52); put(1, 48);
        put(2, 67); put(2, 68); put(2, 66);
        outer(50, 0, "R5 three patterns");
    endtask

    task automatic t_wrap_scale;
        end_event(0, 0);
        put(1, 1); put(2, 0); put(2, 100);
        outer(127, 0, "R4 wraparound");
        put(1, 80); put(1, 75);
        outer(75, 0, "R3 scaled layer two");
    endtask

    task automatic t_eoe;
        end_event(0, 0);
        put(1, 10); put(2, 14);
        end_event(1, 30);
        put(2, 40);
        outer(10, 0, "R7 cleared");
        outer(30, 0, "R7 same-cycle hit kept");
    endtask

    task automatic t_drop;
        end_event(0, 0);
        put(0, 20); put(0, 21);
        chk(drop_count == 8'(drops), "R8 drop count", int'(drop_count), drops);
        put(2, 27);
        outer(20, 0, "R8 tag zero ignored");
    endtask

    task automatic t_backpressure;
        end_event(0, 0);
        put(1, 60); put(1, 62); put(2, 80); put(2, 81);
        outer(60, 3, "R9 stall");
    endtask

    initial begin
        rst = 1'b1; hit_valid = 1'b0; hit_layer = 2'd0; hit_phi = 7'd0;
        evt_end = 1'b0; trip_ready = 1'b1; m1 = '0; m2 = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_single;
        t_multi;
        t_wrap_scale;
        t_eoe;
        t_drop;
        t_backpressure;
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule